// File: doc/BRIEF.md
# I2C Clock-Low Timeout Monitor

This block sits beside an I2C master and watches the clock line for a remote slave that stretches SCL low for too long. A programmable reload value sets the allowed continuous low time, in system clock cycles. A down-counter runs only while the synchronized SCL stays low. Any sample of SCL high reloads the counter, so only an unbroken low stretch can reach zero. When the count runs out, two flags are raised together:
- a sticky raw interrupt, which software clears by writing one;
- a timeout status, which the master's control logic clears when it has put a STOP on the bus.

The same synchronizer that feeds the counter also drives two bus monitor bits. These bits report the current SCL and SDA levels, so software can judge the state of the slave before it tries to recover the bus.

The counter is run by a four-state machine:
- OFF: the block is disabled.
- ARMED: the line is high, or the counter has just been reloaded.
- COUNTING: the line is low and the counter is decrementing.
- EXPIRED: the line is still low after expiry, and the counter rests at zero.

The transitions are:
- any state to OFF when the enable is low;
- OFF to ARMED when the enable is high;
- ARMED to COUNTING on a low sample with a count above one;
- ARMED or COUNTING to EXPIRED on a low sample with a count of one or less;
- COUNTING or EXPIRED to ARMED on a high sample.

Top module: `i2c_clklow_monitor`

## Requirements
- R1: SCL and SDA each pass through two flip-flops before any use. `mon_scl_o` and `mon_sda_o` show an input level two clock edges after it is applied. Both read 1 out of reset.
- R2: While enabled, the counter decrements on every cycle in which the synchronized SCL is low. Expiry occurs on the edge that ends the Nth consecutive low sample, where N is `reload_i`. A reload value of 0 behaves as 1.
- R3: Any single high sample of the synchronized SCL reloads the counter from `reload_i`. The next low stretch then needs a full N low samples to expire.
- R4: Expiry sets `raw_int_o` and `timeout_o` on the same edge. Expiry fires at most once per low stretch: the counter holds at zero until SCL is sampled high, and no further expiry occurs.
- R5: `raw_int_o` stays set until a cycle with `int_clr_i` high clears it. `int_clr_i` has no effect on `timeout_o`.
- R6: `timeout_o` clears only on a cycle with `stop_sent_i` high, or on reset. `stop_sent_i` has no effect on `raw_int_o`.
- R7: If an expiry falls in the same cycle as `int_clr_i` or `stop_sent_i`, the set wins and the flag stays 1.
- R8: While `enable_i` is low, the counter holds the reload value and neither flag can be set. Flags that are already set are kept. After the enable rises with SCL low, expiry follows N+1 edges later.
- R9: An active-low `rst_n` clears both flags and returns the machine to OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| enable_i | input | 1 | Timeout detection enable |
| reload_i | input | CNT_W | Allowed continuous low time in clock cycles |
| stop_sent_i | input | 1 | One-cycle pulse, STOP put on the bus |
| int_clr_i | input | 1 | Write-one-to-clear strobe for the raw interrupt |
| raw_int_o | output | 1 | Sticky raw clock-timeout interrupt |
| timeout_o | output | 1 | Timeout status, cleared by STOP |
| mon_scl_o | output | 1 | Synchronized SCL level |
| mon_sda_o | output | 1 | Synchronized SDA level |

## Verification
An expiry can land on the same edge as an interrupt clear or a STOP notification. The bench provokes this case directly. It first leaves the raw interrupt set. It then starts a fresh low stretch and raises both `int_clr_i` and `stop_sent_i` for exactly the cycle whose edge completes the Nth low sample. Both flags must read 1 after that edge. A design that gives priority to the clear would show 0.

// File: rtl/i2c_clklow_pkg.sv
package i2c_clklow_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMED,
        ST_COUNTING,
        ST_EXPIRED
    } clklow_state_e;

endpackage

// File: rtl/clklow_sync.sv
module clklow_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[LAST];
    end

endmodule

// File: rtl/clklow_counter.sv
module clklow_counter
    import i2c_clklow_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             scl_low_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    clklow_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state, next count and expiry strobe
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (!enable_i) begin
            state_d = ST_OFF;
            cnt_d   = reload_i;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_ARMED;
                    cnt_d   = reload_i;
                end
                ST_ARMED, ST_COUNTING: begin
                    if (!scl_low_i) begin
                        state_d = ST_ARMED;
                        cnt_d   = reload_i;
                    end else if (cnt_q <= ONE) begin
                        state_d  = ST_EXPIRED;
                        cnt_d    = '0;
                        expire_o = 1'b1;
                    end else begin
                        state_d = ST_COUNTING;
                        cnt_d   = cnt_q - ONE;
                    end
                end
                ST_EXPIRED: begin
                    if (!scl_low_i) begin
                        state_d = ST_ARMED;
                        cnt_d   = reload_i;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = reload_i;
                end
            endcase
        end
    end

    assert_reload_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !scl_low_i && state_q != ST_OFF) |=> (cnt_q == $past(reload_i)));

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && scl_low_i && (state_q == ST_ARMED || state_q == ST_COUNTING) && cnt_q > ONE)
        |=> (cnt_q == $past(cnt_q) - ONE));

    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && scl_low_i && state_q == ST_EXPIRED) |=> (state_q == ST_EXPIRED && cnt_q == '0));

    assert_single_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED) |-> !expire_o);

    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == ST_OFF && cnt_q == $past(reload_i)));

endmodule

// File: rtl/clklow_flags.sv
module clklow_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic int_clr_i,
    input  logic stop_sent_i,
    output logic raw_int_o,
    output logic timeout_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_int_o <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            raw_int_o <= expire_i | (raw_int_o & ~int_clr_i);
            timeout_o <= expire_i | (timeout_o & ~stop_sent_i);
        end
    end

    assert_set_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> (raw_int_o && timeout_o));

    assert_int_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_int_o && !int_clr_i) |=> raw_int_o);

    assert_timeout_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !stop_sent_i) |=> timeout_o);

    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_sent_i && !expire_i) |=> !timeout_o);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && (int_clr_i || stop_sent_i)) |=> (raw_int_o && timeout_o));

endmodule

// File: rtl/i2c_clklow_monitor.sv
module i2c_clklow_monitor
    import i2c_clklow_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             stop_sent_i,
    input  logic             int_clr_i,
    output logic             raw_int_o,
    output logic             timeout_o,
    output logic             mon_scl_o,
    output logic             mon_sda_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] line_sync;
    logic             expire;

    clklow_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_sync)
    );

    assign mon_scl_o = line_sync[1];
    assign mon_sda_o = line_sync[0];

    clklow_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .scl_low_i (~line_sync[1]),
        .reload_i  (reload_i),
        .expire_o  (expire)
    );

    clklow_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire_i    (expire),
        .int_clr_i   (int_clr_i),
        .stop_sent_i (stop_sent_i),
        .raw_int_o   (raw_int_o),
        .timeout_o   (timeout_o)
    );

    assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_int_o) |-> $past(enable_i));

    assert_expiry_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> !mon_scl_o);

endmodule

// File: tb/tb_i2c_clklow_monitor.sv
module tb_i2c_clklow_monitor;

    localparam int CNT_W  = 16;
    localparam int RELOAD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             scl_i, sda_i, enable_i, stop_sent_i, int_clr_i;
    logic [CNT_W-1:0] reload_i;
    logic             raw_int_o, timeout_o, mon_scl_o, mon_sda_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    i2c_clklow_monitor #(.CNT_W(CNT_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .enable_i    (enable_i),
        .reload_i    (reload_i),
        .stop_sent_i (stop_sent_i),
        .int_clr_i   (int_clr_i),
        .raw_int_o   (raw_int_o),
        .timeout_o   (timeout_o),
        .mon_scl_o   (mon_scl_o),
        .mon_sda_o   (mon_sda_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // R9, R1: reset state
    task automatic test_reset();
        check("R9", "raw_int after reset", raw_int_o, 1'b0);
        check("R9", "timeout after reset", timeout_o, 1'b0);
        check("R1", "mon_scl after reset", mon_scl_o, 1'b1);
        check("R1", "mon_sda after reset", mon_sda_o, 1'b1);
    endtask

    // R1: two-edge latency of the monitor bits
    task automatic test_monitor();
        sda_i = 1'b0;
        tick(1);
        check("R1", "mon_sda after one edge", mon_sda_o, 1'b1);
        tick(1);
        check("R1", "mon_sda after two edges", mon_sda_o, 1'b0);
        sda_i = 1'b1;
        tick(2);
        check("R1", "mon_sda back high", mon_sda_o, 1'b1);
    endtask

    // R2, R4: exact expiry point
    task automatic test_expiry();
        scl_i = 1'b0;
        tick(RELOAD + 1);
        check("R2", "raw_int one edge early", raw_int_o, 1'b0);
        check("R2", "timeout one edge early", timeout_o, 1'b0);
        tick(1);
        check("R4", "raw_int at expiry", raw_int_o, 1'b1);
        check("R4", "timeout at expiry", timeout_o, 1'b1);
    endtask

    // R4, R5: no second expiry while SCL stays low; the clear leaves timeout set
    task automatic test_once_and_clear();
        int_clr_i = 1'b1;
        tick(1);
        int_clr_i = 1'b0;
        check("R5", "raw_int cleared", raw_int_o, 1'b0);
        check("R5", "timeout untouched by clear", timeout_o, 1'b1);
        tick(3 * RELOAD);
        check("R4", "no re-fire while held low", raw_int_o, 1'b0);
        scl_i = 1'b1;
        tick(3);
    endtask

    // R6: STOP clears timeout only
    task automatic test_stop();
        scl_i = 1'b0;
        tick(RELOAD + 2);
        check("R4", "second stretch expires", raw_int_o, 1'b1);
        scl_i = 1'b1;
        stop_sent_i = 1'b1;
        tick(1);
        stop_sent_i = 1'b0;
        check("R6", "timeout cleared by stop", timeout_o, 1'b0);
        check("R6", "raw_int untouched by stop", raw_int_o, 1'b1);
        tick(RELOAD);
        check("R6", "timeout stays clear", timeout_o, 1'b0);
    endtask

    // R3: a single high sample restarts the count
    task automatic test_glitch();
        int_clr_i = 1'b1;
        tick(1);
        int_clr_i = 1'b0;
        scl_i = 1'b0;
        tick(RELOAD - 1);
        scl_i = 1'b1;
        tick(1);
        scl_i = 1'b0;
        check("R3", "no expiry before glitch", raw_int_o, 1'b0);
        tick(RELOAD + 1);
        check("R3", "count restarted after glitch", raw_int_o, 1'b0);
        tick(1);
        check("R3", "expiry after full new stretch", raw_int_o, 1'b1);
        scl_i = 1'b1;
        tick(3);
    endtask

    // R7: expiry on the same edge as clear and stop
    task automatic test_coincide();
        scl_i = 1'b0;
        tick(RELOAD + 1);
        int_clr_i   = 1'b1;
        stop_sent_i = 1'b1;
        tick(1);
        int_clr_i   = 1'b0;
        stop_sent_i = 1'b0;
        check("R7", "raw_int set wins over clear", raw_int_o, 1'b1);
        check("R7", "timeout set wins over stop", timeout_o, 1'b1);
        scl_i = 1'b1;
        tick(3);
    endtask

    // R8: disabled counter and enable rising during a low stretch
    task automatic test_disable();
        enable_i = 1'b0;
        tick(1);
        check("R8", "flags kept when disabled", raw_int_o, 1'b1);
        int_clr_i   = 1'b1;
        stop_sent_i = 1'b1;
        tick(1);
        int_clr_i   = 1'b0;
        stop_sent_i = 1'b0;
        scl_i = 1'b0;
        tick(3 * RELOAD);
        check("R8", "no raw_int while disabled", raw_int_o, 1'b0);
        check("R8", "no timeout while disabled", timeout_o, 1'b0);
        enable_i = 1'b1;
        tick(RELOAD);
        check("R8", "no expiry one edge early after enable", raw_int_o, 1'b0);
        tick(1);
        check("R8", "expiry after enable", raw_int_o, 1'b1);
        scl_i = 1'b1;
        tick(3);
    endtask

    // R2: reload value 0 behaves as 1
    task automatic test_reload_zero();
        int_clr_i = 1'b1;
        tick(1);
        int_clr_i = 1'b0;
        reload_i = '0;
        tick(2);
        scl_i = 1'b0;
        tick(2);
        check("R2", "reload 0 not yet expired", raw_int_o, 1'b0);
        tick(1);
        check("R2", "reload 0 expires after one low sample", raw_int_o, 1'b1);
        scl_i = 1'b1;
        reload_i = CNT_W'(RELOAD);
        tick(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        scl_i       = 1'b1;
        sda_i       = 1'b1;
        enable_i    = 1'b1;
        stop_sent_i = 1'b0;
        int_clr_i   = 1'b0;
        reload_i    = CNT_W'(RELOAD);
        tick(3);
        test_reset();
        rst_n = 1'b1;
        tick(3);
        test_monitor();
        test_expiry();
        test_once_and_clear();
        test_stop();
        test_glitch();
        test_coincide();
        test_disable();
        test_reload_zero();
        rst_n = 1'b0;
        tick(1);
        check("R9", "reset clears raw_int", raw_int_o, 1'b0);
        check("R9", "reset clears timeout", timeout_o, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule